// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs the external bus cycles of a small 8-bit processor. The bus shares pins between the low address byte and data, and each cycle is counted in clock periods (T-states). A core asks for one bus cycle at a time through a request port that carries the cycle kind, a 16-bit address and a write byte. The block drives the dedicated high address byte, the shared low address/data byte, an address-latch strobe, a memory/IO select, and active-low read and write strobes. When a read or fetch ends, it returns the byte it sampled together with a one-clock done pulse.

One T-state is one clock period. At 2 MHz that is 0.5 µs, so a fetch followed by a memory read (7 T-states) takes 3.5 µs. In T1 the latch strobe is high and the shared pins carry the low address byte. In T2 and T3 the read or write strobe is low. In a read the shared pins are released, and in a write they carry the data. An opcode fetch adds a fourth T-state that has no strobe and leaves the shared pins released.

A DMA master can take the bus with a hold request. The block samples hold only at a cycle boundary, so a cycle that has begun always completes. It then grants the bus and floats every bus output until hold is removed. The request side is valid/ready. A requester keeps `req_valid` and its fields steady until `req_ready` is high at a rising edge. `req_ready` is high only at a cycle boundary while hold is low. The done pulse has no back-pressure: it lasts one clock and must be taken in that clock. Tri-state is modelled as separate output-enable signals.

Top module: `mbs_bus_seq`

## Requirements
- R1: During reset and right after it the block is idle: `ale`=0, `rd_n`=1, `wr_n`=1, `hlda`=0, `rsp_valid`=0, `ad_oe`=0, `bus_oe`=1, `req_ready`=1 (with hold low).
- R2: An opcode fetch (`req_kind`=0) lasts exactly 4 T-states. Its next boundary (`req_ready` high) is the fourth clock after acceptance, and `req_ready` is low in T3.
- R3: A memory read (`req_kind`=1) or memory write (`req_kind`=2) lasts exactly 3 T-states. `req_ready` is high again in T3.
- R4: In T1, `ale`=1 for exactly one clock, `addr_hi` carries address bits 15..8, `ad_out` carries bits 7..0 with `ad_oe`=1, and both strobes are high.
- R5: In T2 and T3 of a fetch or read, `rd_n`=0, `wr_n`=1, `io_m`=0 and `ad_oe`=0.
- R6: In T2 and T3 of a write, `wr_n`=0, `rd_n`=1, `io_m`=0, `ad_oe`=1 and `ad_out` equals the write byte.
- R7: For a fetch or read, `ad_in` is sampled at the rising edge that ends T3. Every cycle raises `rsp_valid` for exactly one clock after T3, and `rsp_rdata` holds the sampled byte.
- R8: T4 of a fetch has both strobes high, `ale`=0 and `ad_oe`=0.
- R9: Hold is sampled only at a boundary and takes priority over a pending request. A cycle already under way completes, and `hlda` rises on the edge that ends the cycle.
- R10: While `hlda`=1, `bus_oe`=0, `ad_oe`=0, both strobes are high and `req_ready`=0, so a pending request waits.
- R11: `hlda` falls at the first rising edge after hold is seen low, and a waiting request is accepted at the next edge.
- R12: `rd_n` and `wr_n` are never low together.
- R13: A request presented at the last T-state of a cycle is accepted there, and its T1 follows with no idle clock.
- R14: The reserved kind code 3 runs as a memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one T-state |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge (boundary and no hold) |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 treated as read |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-clock done pulse |
| rsp_rdata | output | 8 | Byte sampled at the end of T3 |
| addr_hi | output | 8 | High address byte lines |
| ad_out | output | 8 | Shared low address/data, driven value |
| ad_in | input | 8 | Shared low address/data, pin value |
| ad_oe | output | 1 | Drive enable for the shared byte |
| ale | output | 1 | Address latch strobe |
| io_m | output | 1 | Memory/IO select, low for memory |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bus_oe | output | 1 | Drive enable for `addr_hi`, `ale`, `io_m`, `rd_n`, `wr_n` |
| hold | input | 1 | Bus request from a DMA master |
| hlda | output | 1 | Bus granted |

## Verification
The bench changes `ad_in` between T2 and T3, so a design that sampled one edge early would return the wrong byte. It watches where `req_ready` comes back. If a fetch dropped its fourth state, or a read grew a fourth state, the boundary would shift. It raises hold in the middle of a read. A design that granted at once would cut the strobes short. It presents a request while the bus is granted, and that request must wait until `hlda` falls. It starts a second cycle at the last T-state of the first, where an extra idle clock would move `ale` one cycle late.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_RSVD  = 2'd3
  } cyc_kind_e;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_T4   = 3'd4,
    TS_HELD = 3'd5
  } tstate_e;
endpackage

// File: rtl/mbs_sequencer.sv
module mbs_sequencer
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              hold,
  output logic              req_ready,
  output tstate_e           tstate,
  output logic              cur_fetch,
  output logic              cur_write,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_wdata
);
  tstate_e nxt;
  logic    boundary;
  logic    accept;

  // A boundary is idle or the final T-state of the running cycle.
  assign boundary  = (tstate == TS_IDLE) || (tstate == TS_T4) ||
                     ((tstate == TS_T3) && !cur_fetch);
  assign req_ready = boundary && !hold;
  assign accept    = req_ready && req_valid;

  always_comb begin
    nxt = tstate;
    if (tstate == TS_HELD) begin
      nxt = hold ? TS_HELD : TS_IDLE;
    end else if (boundary) begin
      if (hold)           nxt = TS_HELD;
      else if (req_valid) nxt = TS_T1;
      else                nxt = TS_IDLE;
    end else begin
      case (tstate)
        TS_T1:   nxt = TS_T2;
        TS_T2:   nxt = TS_T3;
        TS_T3:   nxt = TS_T4;
        default: nxt = TS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tstate    <= TS_IDLE;
      cur_fetch <= 1'b0;
      cur_write <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
    end else begin
      tstate <= nxt;
      if (accept) begin
        cur_fetch <= (req_kind == KIND_FETCH);
        cur_write <= (req_kind == KIND_WRITE);
        cur_addr  <= req_addr;
        cur_wdata <= req_wdata;
      end
    end
  end
endmodule

// File: rtl/mbs_pin_drive.sv
module mbs_pin_drive
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  tstate_e           tstate,
  input  logic              cur_write,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [DATA_W-1:0] cur_wdata,
  output logic [HI_W-1:0]   addr_hi,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              ale,
  output logic              io_m,
  output logic              rd_n,
  output logic              wr_n,
  output logic              bus_oe,
  output logic              hlda
);
  always_comb begin
    addr_hi = cur_addr[ADDR_W-1:DATA_W];
    ad_out  = '0;
    ad_oe   = 1'b0;
    ale     = 1'b0;
    io_m    = 1'b0;
    rd_n    = 1'b1;
    wr_n    = 1'b1;
    bus_oe  = 1'b1;
    hlda    = 1'b0;
    case (tstate)
      TS_T1: begin
        ale    = 1'b1;
        ad_oe  = 1'b1;
        ad_out = cur_addr[DATA_W-1:0];
      end
      TS_T2, TS_T3: begin
        if (cur_write) begin
          wr_n   = 1'b0;
          ad_oe  = 1'b1;
          ad_out = cur_wdata;
        end else begin
          rd_n = 1'b0;
        end
      end
      TS_HELD: begin
        bus_oe = 1'b0;
        hlda   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mbs_read_capture.sv
module mbs_read_capture
  import mbs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tstate_e           tstate,
  input  logic              cur_write,
  input  logic [DATA_W-1:0] ad_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= (tstate == TS_T3);
      if ((tstate == TS_T3) && !cur_write) rsp_rdata <= ad_in;
    end
  end
endmodule

// File: rtl/mbs_bus_seq.sv
module mbs_bus_seq
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [HI_W-1:0]   addr_hi,
  output logic [DATA_W-1:0] ad_out,
  input  logic [DATA_W-1:0] ad_in,
  output logic              ad_oe,
  output logic              ale,
  output logic              io_m,
  output logic              rd_n,
  output logic              wr_n,
  output logic              bus_oe,
  input  logic              hold,
  output logic              hlda
);
  tstate_e           tstate;
  logic              cur_fetch;
  logic              cur_write;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;

  mbs_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .hold(hold),
    .req_ready(req_ready), .tstate(tstate), .cur_fetch(cur_fetch),
    .cur_write(cur_write), .cur_addr(cur_addr), .cur_wdata(cur_wdata)
  );

  mbs_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .tstate(tstate), .cur_write(cur_write), .cur_addr(cur_addr),
    .cur_wdata(cur_wdata), .addr_hi(addr_hi), .ad_out(ad_out),
    .ad_oe(ad_oe), .ale(ale), .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n),
    .bus_oe(bus_oe), .hlda(hlda)
  );

  mbs_read_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .tstate(tstate), .cur_write(cur_write),
    .ad_in(ad_in), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/mbs_bus_seq_chk.sv
module mbs_bus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic ad_oe,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic bus_oe,
  input logic hold,
  input logic hlda
);
  a_r12_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  a_r4_ale_with_address: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && bus_oe && rd_n && wr_n));

  a_r4_ale_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  a_r5_read_floats_ad: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  a_r5_read_after_ale: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> $past(ale));

  a_r9_read_runs_two_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |=> !rd_n);

  a_r6_write_drives_ad: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);

  a_r10_float_when_granted: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (!bus_oe && !ad_oe && !req_ready && rd_n && wr_n));

  a_r11_release_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (hlda && !hold) |=> !hlda);

  a_r9_grant_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> $past(hold));

  a_r7_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!rd_n || !wr_n));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind mbs_bus_seq mbs_bus_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .ad_oe(ad_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .bus_oe(bus_oe),
  .hold(hold), .hlda(hlda)
);

// File: tb/mbs_bus_seq_test.sv
module mbs_bus_seq_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, req_valid, req_ready, rsp_valid, ad_oe, ale, io_m;
  logic        rd_n, wr_n, bus_oe, hold, hlda;
  logic [1:0]  req_kind;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata, rsp_rdata, addr_hi, ad_out, ad_in;

  int n_chk  = 0;
  int n_fail = 0;

  mbs_bus_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .addr_hi(addr_hi),
    .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe), .ale(ale), .io_m(io_m),
    .rd_n(rd_n), .wr_n(wr_n), .bus_oe(bus_oe), .hold(hold), .hlda(hlda)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; hold = 1'b0;
    req_kind = 2'd0; req_addr = '0; req_wdata = '0; ad_in = '0;
    repeat (3) @(negedge clk);
    check("R1 ale in reset", ale, 0);
    check("R1 rd_n in reset", rd_n, 1);
    check("R1 wr_n in reset", wr_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 hlda", hlda, 0);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 ad_oe", ad_oe, 0);
    check("R1 bus_oe", bus_oe, 1);
    check("R1 req_ready", req_ready, 1);
  endtask

  // Runs one cycle from idle and returns at the next idle negedge.
  task automatic do_cycle(input logic [1:0] kind, input logic [15:0] addr,
                          input logic [7:0] wd, input logic [7:0] rb);
    logic is_wr, is_f;
    is_wr = (kind == 2'd2);
    is_f  = (kind == 2'd0);
    req_kind = kind; req_addr = addr; req_wdata = wd; req_valid = 1'b1;
    ad_in = ~rb;
    #1 check("R13 ready at idle boundary", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R4 ale in T1", ale, 1);
    check("R4 addr_hi in T1", addr_hi, addr[15:8]);
    check("R4 ad_out low addr", ad_out, addr[7:0]);
    check("R4 ad_oe in T1", ad_oe, 1);
    check("R4 strobes off in T1", {rd_n, wr_n}, 2'b11);
    for (int t = 2; t <= 3; t++) begin
      @(negedge clk);
      if (t == 3) ad_in = rb;
      if (is_wr) begin
        check("R6 write strobes", {rd_n, wr_n}, 2'b10);
        check("R6 ad driven", ad_oe, 1);
        check("R6 write byte", ad_out, wd);
      end else begin
        check("R5 R14 read strobes", {rd_n, wr_n}, 2'b01);
        check("R5 R14 ad released", ad_oe, 0);
      end
      check("R5 R6 io_m memory", io_m, 0);
      check("R5 ale low", ale, 0);
    end
    check("R2 R3 ready in T3", req_ready, is_f ? 1'b0 : 1'b1);
    @(negedge clk);
    ad_in = 8'h00;
    check("R7 done pulse", rsp_valid, 1);
    if (!is_wr) check("R7 read byte from end of T3", rsp_rdata, rb);
    check("R8 R3 strobes off", {rd_n, wr_n}, 2'b11);
    check("R8 R3 ad released", ad_oe, 0);
    check("R8 R3 ale low", ale, 0);
    check("R2 R3 boundary", req_ready, 1);
    if (is_f) begin
      @(negedge clk);
      check("R7 done single", rsp_valid, 0);
      check("R2 no new T1", ale, 0);
    end
  endtask

  task automatic t_back2back();
    req_kind = 2'd1; req_addr = 16'h1234; req_valid = 1'b1; ad_in = 8'h5A;
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R13 ready in T3", req_ready, 1);
    req_kind = 2'd2; req_addr = 16'hBEEF; req_wdata = 8'hC3; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    check("R13 read done", rsp_valid, 1);
    check("R13 read byte", rsp_rdata, 8'h5A);
    check("R13 T1 no gap", ale, 1);
    check("R13 new addr_hi", addr_hi, 8'hBE);
    check("R13 new low addr", ad_out, 8'hEF);
    @(negedge clk);
    check("R13 write strobe", wr_n, 0);
    check("R13 write byte", ad_out, 8'hC3);
    @(negedge clk);
    @(negedge clk);
    check("R13 write done", rsp_valid, 1);
  endtask

  task automatic t_hold_idle();
    hold = 1'b1; req_kind = 2'd1; req_addr = 16'h0F0F; req_valid = 1'b1;
    #1 check("R9 hold beats request", req_ready, 0);
    @(negedge clk);
    check("R10 granted", hlda, 1);
    check("R10 bus floated", bus_oe, 0);
    check("R10 ad floated", ad_oe, 0);
    check("R10 no T1 while held", ale, 0);
    hold = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    check("R11 hlda falls", hlda, 0);
    check("R11 bus back", bus_oe, 1);
  endtask

  task automatic t_hold_mid();
    req_kind = 2'd1; req_addr = 16'hA55A; req_valid = 1'b1; ad_in = 8'h77;
    @(negedge clk); req_valid = 1'b0; hold = 1'b1;
    check("R9 T1 runs", ale, 1);
    @(negedge clk);
    check("R9 no grant mid-cycle T2", hlda, 0);
    check("R9 read strobe T2", rd_n, 0);
    @(negedge clk);
    check("R9 no grant mid-cycle T3", hlda, 0);
    check("R9 read strobe T3", rd_n, 0);
    check("R9 no ready under hold", req_ready, 0);
    @(negedge clk);
    check("R9 grant at cycle end", hlda, 1);
    check("R9 cycle completed", rsp_valid, 1);
    check("R9 byte", rsp_rdata, 8'h77);
    check("R10 bus floated", bus_oe, 0);
    req_kind = 2'd2; req_addr = 16'h3344; req_wdata = 8'h99; req_valid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R10 request waits", req_ready, 0);
      check("R10 strobes off", {ale, rd_n, wr_n}, 3'b011);
    end
    hold = 1'b0;
    #1 check("R11 still granted", hlda, 1);
    @(negedge clk);
    check("R11 hlda falls", hlda, 0);
    check("R11 ready for waiting request", req_ready, 1);
    @(negedge clk); req_valid = 1'b0;
    check("R11 waiting request T1", ale, 1);
    check("R11 waiting addr", addr_hi, 8'h33);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    report();
  end

  initial begin
    t_reset();
    do_cycle(2'd1, 16'h12AB, 8'h00, 8'h3C);
    do_cycle(2'd2, 16'hFE01, 8'hA6, 8'h00);
    do_cycle(2'd0, 16'h2000, 8'h00, 8'h3E);
    do_cycle(2'd3, 16'h8001, 8'h00, 8'hE1);
    t_back2back();
    t_hold_idle();
    t_hold_mid();
    do_cycle(2'd0, 16'hFFFF, 8'h00, 8'h00);
    report();
  end
endmodule